// File: doc/BRIEF.md
# Byte-Wide Indirect Host Port Bridge

This block lets a host with an 8-bit parallel bus reach an internal address space of up to 19 bits through a small request/acknowledge port. The host drives chip select, read strobe, write strobe, a command/data select line and an 8-bit data bus. Command bytes (select line low) program a start address in three steps. The first byte is a header that picks either the memory region or the register region and supplies the top address bits. The next two bytes give the middle byte and then the low byte of the address. Data bytes (select line high) then stream as a burst, and each byte moves to the next sequential address.

Writes become internal write requests. Reads are prefetched one access ahead into a holding register. Each read strobe returns the byte fetched by the previous read and starts the fetch of the next one. The first read after an address is programmed therefore returns a dummy value. A run of zero-valued command bytes closes an open read burst. Every host access counts a fixed number of internal clock edges before it takes effect, so that the strobe timing is met when no wait line is used.

Top module: `byte_host_bridge`

## Requirements
- R1: A host access takes effect on the CYCLE_LEN-th (default 7) consecutive rising clock edge at which chip select and a strobe are seen low, and only once per strobe. A strobe that is released before that edge has no effect.
- R2: Command bytes (select line 0) are taken in a fixed sequence: header, then address bits 15:8, then address bits 7:0. In the header, bit 7 = 1 selects memory and 0 selects register access, and bits 2:0 are address bits 18:16. The resulting address and region appear on `bus_addr` and `bus_mem`.
- R3: A header whose bits 6:3 are not all zero sets `hdr_err` and is otherwise ignored. The next command byte is again taken as a header.
- R4: Each data write issues one request with `bus_we`=1, the current address and the written byte. The address then moves up by one.
- R5: The first data read after the address is programmed returns 0x00 and launches the read of address N. Each later read returns the byte fetched by the read before it and launches the read of the next address.
- R6: While a read burst is open, TERM_LEN (default 3) consecutive command bytes of 0x00 close it. After that, data accesses issue no request until a new address is programmed.
- R7: A data byte that arrives after the header but before the low address byte is ignored, and the setup sequence restarts at the header.
- R8: Data accesses before any address has been programmed issue no request.
- R9: `bus_req`, `bus_addr`, `bus_we`, `bus_mem` and `bus_wdata` stay constant from the raising of a request until the cycle `bus_ack` is seen.
- R10: After reset `bus_req`=0, `hdr_err`=0 and `hst_dout`=0x00. `hdr_err`, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_cs_n | input | 1 | Host chip select, active low |
| hst_rd_n | input | 1 | Host read strobe, active low |
| hst_wr_n | input | 1 | Host write strobe, active low |
| hst_dc | input | 1 | 0 = command (address setup) byte, 1 = data byte |
| hst_din | input | 8 | Host write data |
| hst_dout | output | 8 | Host read data |
| hst_dout_oe | output | 1 | Read data drive enable |
| bus_req | output | 1 | Internal access request |
| bus_we | output | 1 | 1 = write request, 0 = read request |
| bus_mem | output | 1 | 1 = memory region, 0 = register region |
| bus_addr | output | ADDR_W | Request address |
| bus_wdata | output | 8 | Request write data |
| bus_ack | input | 1 | Request accepted and completed |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| hdr_err | output | 1 | Sticky malformed-header flag |

## Verification
On every cycle the bound properties check four things. A request stays frozen until it is acknowledged. Every new request follows an edge where the host strobe was active. A write request carries the byte that was on the host bus when it took effect. The header error flag never clears. The one-access read lag and the dummy first read are shown only by the scenarios, as are the termination sequence, the restart of a broken setup and the dropping of short strobes. A scoreboard matches every internal request against the address sequence the bench derives from its own setup bytes.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
   typedef enum logic [1:0] {
      SU_HDR = 2'd0,
      SU_HI  = 2'd1,
      SU_LO  = 2'd2
   } su_state_e;

   typedef struct packed {
      logic       is_rd;
      logic       is_data;
      logic [7:0] byte_v;
   } host_acc_t;
endpackage

// File: rtl/hbp_strobe_timer.sv
module hbp_strobe_timer #(
   parameter int CYCLE_LEN = 7,
   parameter bit SYNC_IN   = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                rd_n,
   input  logic                wr_n,
   input  logic                dc,
   input  logic [7:0]          din,
   input  logic                ready,
   output logic                start_rd,
   output logic                commit,
   output hbp_pkg::host_acc_t  acc
);
   localparam int CW = $clog2(CYCLE_LEN + 1);

   logic       cs_s, rd_s, wr_s, dc_s;
   logic [7:0] din_s;

   generate
      if (SYNC_IN) begin : g_reg_in
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_s  <= 1'b1;
               rd_s  <= 1'b1;
               wr_s  <= 1'b1;
               dc_s  <= 1'b0;
               din_s <= '0;
            end else begin
               cs_s  <= cs_n;
               rd_s  <= rd_n;
               wr_s  <= wr_n;
               dc_s  <= dc;
               din_s <= din;
            end
         end
      end else begin : g_direct_in
         assign cs_s  = cs_n;
         assign rd_s  = rd_n;
         assign wr_s  = wr_n;
         assign dc_s  = dc;
         assign din_s = din;
      end
   endgenerate

   logic          act, act_q, done_q;
   logic [CW-1:0] cnt_q;

   assign act      = !cs_s && (!rd_s || !wr_s);
   assign start_rd = act && !act_q && !rd_s;
   assign commit   = act && !done_q && ready && (cnt_q == CW'(CYCLE_LEN - 1));
   assign acc      = '{is_rd: !rd_s, is_data: dc_s, byte_v: din_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         act_q <= act;
         if (!act) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
         end else begin
            if (cnt_q != CW'(CYCLE_LEN - 1))
               cnt_q <= cnt_q + CW'(1);
            if (commit)
               done_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/hbp_setup_decoder.sv
module hbp_setup_decoder #(
   parameter int ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_fwd,
   input  logic              data_seen,
   input  logic [7:0]        byte_v,
   output logic              hdr_ok,
   output logic              setup_done,
   output logic [ADDR_W-1:0] new_addr,
   output logic              new_mem,
   output logic              err
);
   import hbp_pkg::*;
   localparam int HB = ADDR_W - 16;

   su_state_e     st_q;
   logic [HB-1:0] top_q;
   logic [7:0]    mid_q;
   logic          mem_q;
   logic          rsvd_bad;

   assign rsvd_bad   = |byte_v[6:HB];
   assign hdr_ok     = cmd_fwd && (st_q == SU_HDR) && !rsvd_bad;
   assign setup_done = cmd_fwd && (st_q == SU_LO);
   assign new_addr   = {top_q, mid_q, byte_v};
   assign new_mem    = mem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SU_HDR;
         top_q <= '0;
         mid_q <= '0;
         mem_q <= 1'b0;
         err   <= 1'b0;
      end else if (cmd_fwd) begin
         unique case (st_q)
            SU_HDR: begin
               if (rsvd_bad) begin
                  err <= 1'b1;
               end else begin
                  mem_q <= byte_v[7];
                  top_q <= byte_v[HB-1:0];
                  st_q  <= SU_HI;
               end
            end
            SU_HI: begin
               mid_q <= byte_v;
               st_q  <= SU_LO;
            end
            default: st_q <= SU_HDR;
         endcase
      end else if (data_seen && st_q != SU_HDR) begin
         st_q <= SU_HDR;
      end
   end
endmodule

// File: rtl/hbp_access_engine.sv
module hbp_access_engine #(
   parameter int ADDR_W   = 19,
   parameter int TERM_LEN = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit,
   input  logic               start_rd,
   input  hbp_pkg::host_acc_t acc,
   input  logic               hdr_ok,
   input  logic               setup_done,
   input  logic [ADDR_W-1:0]  new_addr,
   input  logic               new_mem,
   input  logic               ack,
   input  logic [7:0]         rdata,
   output logic               cmd_fwd,
   output logic               data_seen,
   output logic               ready,
   output logic               req,
   output logic               we,
   output logic               mem,
   output logic [ADDR_W-1:0]  addr,
   output logic [7:0]         wdata,
   output logic [7:0]         dout
);
   localparam int TW = $clog2(TERM_LEN + 1);

   logic [ADDR_W-1:0] cur_q;
   logic              cur_mem_q, valid_q, burst_q;
   logic [TW-1:0]     term_q;
   logic [7:0]        hold_q;
   logic              term_byte, cmd_c;

   assign data_seen = commit && acc.is_data;
   assign cmd_c     = commit && !acc.is_data;
   assign term_byte = burst_q && (acc.byte_v == 8'h00);
   assign cmd_fwd   = cmd_c && !term_byte;
   assign ready     = !req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q     <= '0;
         cur_mem_q <= 1'b0;
         valid_q   <= 1'b0;
         burst_q   <= 1'b0;
         term_q    <= '0;
         hold_q    <= '0;
         dout      <= '0;
         req       <= 1'b0;
         we        <= 1'b0;
         mem       <= 1'b0;
         addr      <= '0;
         wdata     <= '0;
      end else begin
         if (start_rd)
            dout <= hold_q;
         if (req && ack) begin
            req <= 1'b0;
            if (!we)
               hold_q <= rdata;
         end
         if (cmd_c && term_byte) begin
            if (term_q == TW'(TERM_LEN - 1)) begin
               burst_q <= 1'b0;
               valid_q <= 1'b0;
               term_q  <= '0;
            end else begin
               term_q <= term_q + TW'(1);
            end
         end
         if (cmd_fwd) begin
            burst_q <= 1'b0;
            term_q  <= '0;
         end
         if (hdr_ok)
            valid_q <= 1'b0;
         if (setup_done) begin
            cur_q     <= new_addr;
            cur_mem_q <= new_mem;
            valid_q   <= 1'b1;
            hold_q    <= '0;
         end
         if (data_seen && valid_q) begin
            req     <= 1'b1;
            we      <= !acc.is_rd;
            mem     <= cur_mem_q;
            addr    <= cur_q;
            wdata   <= acc.byte_v;
            cur_q   <= cur_q + ADDR_W'(1);
            burst_q <= acc.is_rd;
            term_q  <= '0;
         end
      end
   end
endmodule

// File: rtl/byte_host_bridge.sv
module byte_host_bridge #(
   parameter int ADDR_W    = 19,
   parameter int CYCLE_LEN = 7,
   parameter int TERM_LEN  = 3,
   parameter bit SYNC_IN   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_cs_n,
   input  logic              hst_rd_n,
   input  logic              hst_wr_n,
   input  logic              hst_dc,
   input  logic [7:0]        hst_din,
   output logic [7:0]        hst_dout,
   output logic              hst_dout_oe,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_mem,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [7:0]        bus_wdata,
   input  logic              bus_ack,
   input  logic [7:0]        bus_rdata,
   output logic              hdr_err
);
   generate
      if (ADDR_W < 17 || ADDR_W > 19) begin : g_bad_addr_w
         $error("ADDR_W must lie in 17..19");
      end
      if (CYCLE_LEN < 2) begin : g_bad_cycle
         $error("CYCLE_LEN must be at least 2");
      end
      if (TERM_LEN < 1) begin : g_bad_term
         $error("TERM_LEN must be at least 1");
      end
   endgenerate

   hbp_pkg::host_acc_t acc;
   logic              commit, start_rd, ready;
   logic              cmd_fwd, data_seen, hdr_ok, setup_done, new_mem;
   logic [ADDR_W-1:0] new_addr;

   assign hst_dout_oe = !hst_cs_n && !hst_rd_n;

   hbp_strobe_timer #(.CYCLE_LEN(CYCLE_LEN), .SYNC_IN(SYNC_IN)) u_timer (
      .clk(clk), .rst_n(rst_n), .cs_n(hst_cs_n), .rd_n(hst_rd_n),
      .wr_n(hst_wr_n), .dc(hst_dc), .din(hst_din), .ready(ready),
      .start_rd(start_rd), .commit(commit), .acc(acc)
   );

   hbp_setup_decoder #(.ADDR_W(ADDR_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .cmd_fwd(cmd_fwd), .data_seen(data_seen),
      .byte_v(acc.byte_v), .hdr_ok(hdr_ok), .setup_done(setup_done),
      .new_addr(new_addr), .new_mem(new_mem), .err(hdr_err)
   );

   hbp_access_engine #(.ADDR_W(ADDR_W), .TERM_LEN(TERM_LEN)) u_eng (
      .clk(clk), .rst_n(rst_n), .commit(commit), .start_rd(start_rd),
      .acc(acc), .hdr_ok(hdr_ok), .setup_done(setup_done),
      .new_addr(new_addr), .new_mem(new_mem), .ack(bus_ack),
      .rdata(bus_rdata), .cmd_fwd(cmd_fwd), .data_seen(data_seen),
      .ready(ready), .req(bus_req), .we(bus_we), .mem(bus_mem),
      .addr(bus_addr), .wdata(bus_wdata), .dout(hst_dout)
   );
endmodule

// File: rtl/byte_host_bridge_chk.sv
module byte_host_bridge_chk #(
   parameter int ADDR_W  = 19,
   parameter bit SYNC_IN = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hst_cs_n,
   input logic              hst_rd_n,
   input logic              hst_wr_n,
   input logic [7:0]        hst_din,
   input logic              bus_req,
   input logic              bus_we,
   input logic              bus_mem,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic              bus_ack,
   input logic              hdr_err
);
   localparam int LAG = 1 + int'(SYNC_IN);

   AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                 && $stable(bus_mem) && $stable(bus_wdata))); // R9

   AST_REQ_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> $past(!hst_cs_n && (!hst_rd_n || !hst_wr_n), LAG)); // R1

   AST_WDATA_FROM_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_req) && bus_we) |-> (bus_wdata == $past(hst_din, LAG))); // R4

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_err |=> hdr_err); // R10
endmodule

bind byte_host_bridge byte_host_bridge_chk #(.ADDR_W(ADDR_W), .SYNC_IN(SYNC_IN)) u_chk (
   .clk(clk), .rst_n(rst_n), .hst_cs_n(hst_cs_n), .hst_rd_n(hst_rd_n),
   .hst_wr_n(hst_wr_n), .hst_din(hst_din), .bus_req(bus_req), .bus_we(bus_we),
   .bus_mem(bus_mem), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_ack(bus_ack), .hdr_err(hdr_err)
);

// File: tb/byte_host_bridge_test.sv
`timescale 1ns/1ps
module byte_host_bridge_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, dc = 1'b0;
   logic [7:0]  din = '0;
   logic [7:0]  dout;
   logic        dout_oe, req, we, mem, ack = 1'b0, ack_en = 1'b1;
   logic [18:0] addr;
   logic [7:0]  wdata, rdata = '0;
   logic        herr;

   int checks = 0, errors = 0, txns = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   byte_host_bridge uut (
      .clk(clk), .rst_n(rst_n), .hst_cs_n(cs_n), .hst_rd_n(rd_n),
      .hst_wr_n(wr_n), .hst_dc(dc), .hst_din(din), .hst_dout(dout),
      .hst_dout_oe(dout_oe), .bus_req(req), .bus_we(we), .bus_mem(mem),
      .bus_addr(addr), .bus_wdata(wdata), .bus_ack(ack), .bus_rdata(rdata),
      .hdr_err(herr)
   );

   typedef struct {
      bit          we;
      bit          mem;
      logic [18:0] addr;
      logic [7:0]  wd;
   } txn_t;
   txn_t        exp_q[$];
   logic [7:0]  store [logic [19:0]];
   logic [18:0] cur_addr;
   bit          cur_mem;

   function automatic logic [7:0] pat(bit m, logic [18:0] a);
      return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ (m ? 8'hA5 : 8'h3C);
   endfunction

   function automatic logic [7:0] peek(bit m, logic [18:0] a);
      if (store.exists({m, a})) return store[{m, a}];
      return pat(m, a);
   endfunction

   task automatic check(bit ok, string req_tag, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req_tag, act, expv);
      end
   endtask

   // monitor / memory model: acknowledges and pops the scoreboard
   always @(negedge clk) begin
      if (req && !ack && ack_en && rst_n) begin
         txn_t e;
         ack = 1'b1;
         txns++;
         if (!we) rdata = peek(mem, addr);
         else store[{mem, addr}] = wdata;
         if (exp_q.size() == 0) begin
            check(0, "R8 unexpected request", {12'b0, we, mem, addr}, 32'h0);
         end else begin
            e = exp_q.pop_front();
            check(we == e.we && mem == e.mem && addr == e.addr,
                  "R2/R4/R5 request", {12'b0, we, mem, addr}, {12'b0, e.we, e.mem, e.addr});
            if (e.we) check(wdata == e.wd, "R4 write data", wdata, e.wd);
         end
      end else begin
         ack = 1'b0;
      end
   end

   task automatic host_cycle(bit is_rd, bit is_dat, logic [7:0] b, int low, output logic [7:0] seen);
      @(negedge clk);
      cs_n = 1'b0; dc = is_dat; din = b;
      if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
      repeat (low - 1) @(negedge clk);
      seen = dout;
      rd_n = 1'b1; wr_n = 1'b1; cs_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic cmd(logic [7:0] b);
      logic [7:0] s;
      host_cycle(0, 0, b, 10, s);
   endtask

   task automatic setup(logic [7:0] h, logic [7:0] hi, logic [7:0] lo);
      cmd(h); cmd(hi); cmd(lo);
      cur_mem  = h[7];
      cur_addr = {h[2:0], hi, lo};
   endtask

   task automatic wr_data(logic [7:0] b);
      logic [7:0] s;
      exp_q.push_back('{we: 1'b1, mem: cur_mem, addr: cur_addr, wd: b});
      cur_addr++;
      host_cycle(0, 1, b, 10, s);
   endtask

   task automatic rd_data(output logic [7:0] got);
      exp_q.push_back('{we: 1'b0, mem: cur_mem, addr: cur_addr, wd: 8'h00});
      cur_addr++;
      host_cycle(1, 1, 8'h00, 10, got);
   endtask

   task automatic expect_quiet(string tag);
      repeat (4) @(negedge clk);
      check(req == 1'b0 && exp_q.size() == 0, tag, {31'b0, req}, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] g;
      int t0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(req == 0, "R10 req after reset", req, 0);
      check(herr == 0, "R10 err after reset", herr, 0);
      check(dout == 8'h00, "R10 dout after reset", dout, 0);
      check(dout_oe == 0, "R10 oe idle", dout_oe, 0);

      // R8: data before any setup is dropped
      host_cycle(0, 1, 8'h77, 10, g);
      host_cycle(1, 1, 8'h00, 10, g);
      expect_quiet("R8 no request before setup");

      // R2 R4: memory burst writes
      setup(8'h85, 8'h12, 8'hF0);
      wr_data(8'h11); wr_data(8'h22); wr_data(8'h33);
      expect_quiet("R4 burst writes drained");

      // R2: register region
      setup(8'h02, 8'h00, 8'h10);
      wr_data(8'h9C);
      expect_quiet("R2 register write drained");
      check(store.exists({1'b0, 19'h2_0010}), "R2 register region address", 0, 1);

      // R5: read back with dummy first read and one-access lag
      setup(8'h85, 8'h12, 8'hF0);
      rd_data(g); check(g == 8'h00, "R5 dummy read", g, 8'h00);
      rd_data(g); check(g == 8'h11, "R5 read N", g, 8'h11);
      rd_data(g); check(g == 8'h22, "R5 read N+1", g, 8'h22);
      rd_data(g); check(g == 8'h33, "R5 read N+2", g, 8'h33);
      rd_data(g); check(g == pat(1, 19'h5_12F3), "R5 read N+3", g, pat(1, 19'h5_12F3));
      repeat (4) @(negedge clk);

      // R6: termination closes the burst
      cmd(8'h00); cmd(8'h00); cmd(8'h00);
      host_cycle(1, 1, 8'h00, 10, g);
      host_cycle(0, 1, 8'h5A, 10, g);
      expect_quiet("R6 no request after termination");
      check(txns == 9, "R6 transaction count", txns, 9);

      // R3: malformed header flagged and ignored
      cmd(8'h88);
      check(herr == 1, "R3 err set", herr, 1);
      setup(8'h81, 8'h00, 8'h40);
      wr_data(8'hAA);
      expect_quiet("R3 setup after bad header");
      check(herr == 1, "R10 err sticky", herr, 1);

      // R7: data mid-setup is ignored and restarts the sequence
      cmd(8'h80); cmd(8'h12);
      host_cycle(0, 1, 8'h55, 10, g);
      expect_quiet("R7 mid-setup data ignored");
      setup(8'h83, 8'h00, 8'h07);
      wr_data(8'h42);
      expect_quiet("R7 restarted setup");

      // R1: short strobe has no effect, address unchanged
      host_cycle(0, 1, 8'hEE, 4, g);
      expect_quiet("R1 short strobe dropped");
      wr_data(8'h66);
      expect_quiet("R1 full strobe after short one");
      check(store.exists({1'b1, 19'h3_0008}) && store[{1'b1, 19'h3_0008}] == 8'h66,
            "R1 address not advanced by short strobe", 0, 1);

      // R9: request held while unacknowledged
      ack_en = 1'b0;
      t0 = txns;
      wr_data(8'hC3);
      repeat (20) @(negedge clk);
      check(req == 1 && addr == 19'h3_0009 && we == 1, "R9 request held", {12'b0, req, addr}, {13'h1, 19'h3_0009});
      check(txns == t0, "R9 no completion without ack", txns, t0);
      ack_en = 1'b1;
      expect_quiet("R9 completes after ack");

      // R10: reset clears the sticky flag
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check(herr == 0, "R10 err cleared by reset", herr, 0);
      check(req == 0, "R10 req cleared by reset", req, 0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule